// File: doc/BRIEF.md
# SAR Conversion Sequencer with Tagged Output Latch

This block runs one successive-approximation conversion at a time for a multi-channel sampling converter and holds the finished word on a parallel read port. A falling edge on the active-low start input begins a conversion, but only when chip select is low. The sequencer then offers a trial code to an external DAC/comparator pair. It keeps or drops one bit per clock, from the most significant bit down to bit 0. When the last bit has been decided, it stores the result together with the channel tag (the differential flag and the 3-bit input address taken when the conversion started) in one 16-bit latch. The active-low busy output returns high on that same clock edge.

Starts are gated by several conditions. A conversion in progress cannot be restarted. A minimum acquisition interval must pass after each conversion before another start is taken. Shutdown, which is nap or sleep depending on chip select, also blocks starts, as does the wake-up count that runs after shutdown is released. The read port is enabled only while chip select and read are both low. High impedance is represented by an enable flag with the data forced to zero.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A falling edge of `start_n` that is sampled while `cs_n` is low, with the block idle and powered, starts a conversion. `busy_n` reads low in the cycle after the clock edge that saw the edge.
- R2: A falling edge of `start_n` while `cs_n` is high is ignored, and `busy_n` stays high.
- R3: Falling edges of `start_n` during a conversion do not restart it. The conversion ends on schedule with the tag captured at its own start, even if `sel_addr` changes.
- R4: After a start, `trial` shows only the MSB set. Each following cycle decides one lower bit, keeping it when `cmp_keep` is high. `busy_n` stays low for exactly RES_W cycles.
- R5: On completion the latch holds `{sel_diff, sel_addr[2:0], result[11:0]}` (bit 15 differential flag, bits 14:12 address, bits 11:0 result). It is loaded on the same edge at which `busy_n` rises.
- R6: The latch keeps its contents, including throughout a later conversion, until that conversion completes.
- R7: `dout_oe` is high only while `cs_n` and `rd_n` are both low. While it is low, `dout` reads zero.
- R8: `pwr_state` encodes 0 = active, 1 = nap, 2 = sleep, 3 = waking. While `shdn_n` is low, the state is nap if `cs_n` is low and sleep if `cs_n` is high.
- R9: Start edges are ignored in nap, in sleep and while waking.
- R10: The first edge that samples `shdn_n` high after shutdown enters waking. Waking lasts NAP_WAKE+1 cycles after nap and SLEEP_WAKE+1 cycles after sleep, and then the state is active.
- R11: After a completion, a start edge first sampled ACQ_CYC or fewer edges later is ignored. One sampled ACQ_CYC+1 edges later is accepted.
- R12: After reset, `busy_n` is high, `pwr_state` is active, `trial` is zero and the latch reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Conversion start request, active low, falling edge |
| cs_n | input | 1 | Chip select, active low; also selects nap or sleep |
| rd_n | input | 1 | Read enable, active low |
| shdn_n | input | 1 | Shutdown request, active low |
| sel_diff | input | 1 | Differential flag for the tag |
| sel_addr | input | 3 | Input address for the tag |
| cmp_keep | input | 1 | Comparator decision: keep the bit under trial |
| trial | output | RES_W | Trial code presented to the DAC |
| busy_n | output | 1 | Low while a conversion runs |
| dout | output | 4+RES_W | Tagged result when enabled, zero otherwise |
| dout_oe | output | 1 | Read port drive enable |
| pwr_state | output | 2 | Power state code |

## Verification
Suppose the bit index or the trial register goes wrong. The `trial` code then departs from the expected binary search in the very next cycle, and the latched result is wrong when `busy_n` rises, RES_W cycles after the start. A stale or mistimed acquisition counter or wake counter shows at `busy_n` on the first start edge near the window's end, accepted one cycle early or refused one cycle late. The bench probes both sides of each window. A tag captured at the wrong time shows in bits 15:12 of the word read right after completion.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int TAG_W = 4;

    typedef enum logic [1:0] {
        PWR_ON    = 2'd0,
        PWR_NAP   = 2'd1,
        PWR_SLEEP = 2'd2,
        PWR_WAKE  = 2'd3
    } pwr_e;

    typedef struct packed {
        logic       diff;
        logic [2:0] addr;
    } tag_t;

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sar_power.sv
module sar_power
    import sar_pkg::*;
#(
    parameter int NAP_WAKE   = 20,
    parameter int SLEEP_WAKE = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic shdn_n,
    input  logic cs_n,
    output logic ready,
    output pwr_e state
);
    localparam int WMAX   = (SLEEP_WAKE > NAP_WAKE) ? SLEEP_WAKE : NAP_WAKE;
    localparam int WAKE_W = cnt_w(WMAX);

    pwr_e              state_q;
    logic [WAKE_W-1:0] wake_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PWR_ON;
            wake_q  <= '0;
        end else if (!shdn_n) begin
            state_q <= cs_n ? PWR_SLEEP : PWR_NAP;
            wake_q  <= '0;
        end else begin
            unique case (state_q)
                PWR_NAP: begin
                    state_q <= PWR_WAKE;
                    wake_q  <= WAKE_W'(NAP_WAKE);
                end
                PWR_SLEEP: begin
                    state_q <= PWR_WAKE;
                    wake_q  <= WAKE_W'(SLEEP_WAKE);
                end
                PWR_WAKE: begin
                    if (wake_q == '0) state_q <= PWR_ON;
                    else              wake_q  <= wake_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ready = (state_q == PWR_ON);
    assign state = state_q;

endmodule

// File: rtl/sar_step.sv
module sar_step
    import sar_pkg::*;
#(
    parameter int RES_W   = 12,
    parameter int ACQ_CYC = 15
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   go,
    input  tag_t                   tag_in,
    input  logic                   cmp_keep,
    output logic [RES_W-1:0]       trial,
    output logic                   converting,
    output logic                   idle_ok,
    output logic                   done,
    output logic [TAG_W+RES_W-1:0] word_next
);
    localparam int IDX_W = cnt_w(RES_W - 1);
    localparam int ACQ_W = cnt_w(ACQ_CYC);

    logic             conv_q;
    logic [IDX_W-1:0] idx_q;
    logic [RES_W-1:0] sar_q;
    tag_t             tag_q;
    logic [ACQ_W-1:0] acq_q;
    logic [RES_W-1:0] probe;
    logic [RES_W-1:0] kept;

    assign probe = RES_W'(1) << idx_q;
    assign kept  = sar_q | (cmp_keep ? probe : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_q <= 1'b0;
            idx_q  <= '0;
            sar_q  <= '0;
            tag_q  <= '0;
            acq_q  <= '0;
        end else if (go) begin
            conv_q <= 1'b1;
            idx_q  <= IDX_W'(RES_W - 1);
            sar_q  <= '0;
            tag_q  <= tag_in;
        end else if (conv_q) begin
            sar_q <= kept;
            if (idx_q == '0) begin
                conv_q <= 1'b0;
                acq_q  <= ACQ_W'(ACQ_CYC);
            end else begin
                idx_q <= idx_q - 1'b1;
            end
        end else if (acq_q != '0) begin
            acq_q <= acq_q - 1'b1;
        end
    end

    assign trial      = conv_q ? (sar_q | probe) : sar_q;
    assign converting = conv_q;
    assign idle_ok    = !conv_q && (acq_q == '0);
    assign done       = conv_q && (idx_q == '0);
    assign word_next  = {tag_q, kept};

endmodule

// File: rtl/sar_outlatch.sv
module sar_outlatch #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              cs_n,
    input  logic              rd_n,
    output logic [WORD_W-1:0] dout,
    output logic              dout_oe
);
    logic [WORD_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)       hold_q <= '0;
        else if (load) hold_q <= word_in;
    end

    assign dout_oe = !cs_n && !rd_n;
    assign dout    = dout_oe ? hold_q : '0;

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int RES_W      = 12,
    parameter int ACQ_CYC    = 15,
    parameter int NAP_WAKE   = 20,
    parameter int SLEEP_WAKE = 200
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_n,
    input  logic                   cs_n,
    input  logic                   rd_n,
    input  logic                   shdn_n,
    input  logic                   sel_diff,
    input  logic [2:0]             sel_addr,
    input  logic                   cmp_keep,
    output logic [RES_W-1:0]       trial,
    output logic                   busy_n,
    output logic [TAG_W+RES_W-1:0] dout,
    output logic                   dout_oe,
    output logic [1:0]             pwr_state
);
    localparam int WORD_W = TAG_W + RES_W;

    logic              start_q;
    logic              start_fall;
    logic              pwr_ready;
    logic              step_idle;
    logic              go;
    logic              converting;
    logic              done;
    logic [WORD_W-1:0] word_next;
    pwr_e              pwr_q;
    tag_t              tag_in;

    always_ff @(posedge clk) begin
        if (rst) start_q <= 1'b1;
        else     start_q <= start_n;
    end

    assign start_fall = start_q && !start_n;
    assign go         = start_fall && !cs_n && pwr_ready && step_idle;
    assign tag_in     = '{diff: sel_diff, addr: sel_addr};

    sar_power #(.NAP_WAKE(NAP_WAKE), .SLEEP_WAKE(SLEEP_WAKE)) u_pwr (
        .clk    (clk),
        .rst    (rst),
        .shdn_n (shdn_n),
        .cs_n   (cs_n),
        .ready  (pwr_ready),
        .state  (pwr_q)
    );

    sar_step #(.RES_W(RES_W), .ACQ_CYC(ACQ_CYC)) u_step (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .tag_in     (tag_in),
        .cmp_keep   (cmp_keep),
        .trial      (trial),
        .converting (converting),
        .idle_ok    (step_idle),
        .done       (done),
        .word_next  (word_next)
    );

    sar_outlatch #(.WORD_W(WORD_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .load    (done),
        .word_in (word_next),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    assign busy_n    = !converting;
    assign pwr_state = pwr_q;

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk
    import sar_pkg::*;
#(
    parameter int RES_W   = 12,
    parameter int ACQ_CYC = 15
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   start_n,
    input logic                   cs_n,
    input logic [RES_W-1:0]       trial,
    input logic                   busy_n,
    input logic [TAG_W+RES_W-1:0] dout,
    input logic                   dout_oe,
    input logic [1:0]             pwr_state
);
    localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

    int unsigned low_cnt;
    int unsigned idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= 0;
            idle_cnt <= ACQ_CYC + 1;
        end else begin
            low_cnt <= busy_n ? 0 : low_cnt + 1;
            if (!busy_n)                  idle_cnt <= 0;
            else if (idle_cnt <= ACQ_CYC) idle_cnt <= idle_cnt + 1;
        end
    end

    AST_START_QUAL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_n) |-> ($past(!cs_n) && $past(!start_n)));               // R1 R2

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (!busy_n && !$past(busy_n)) |-> (trial != MSB_ONLY));              // R3

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_n) |-> (low_cnt == RES_W));                             // R4

    AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && $past(dout_oe) && !$rose(busy_n)) |-> $stable(dout));  // R6

    AST_OE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> (dout == '0));                                        // R7

    AST_PD_NO_START: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_n) |-> ($past(pwr_state) == PWR_ON));                   // R9

    AST_ACQ_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_n) |-> (idle_cnt > ACQ_CYC));                           // R11

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.RES_W(RES_W), .ACQ_CYC(ACQ_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_n   (start_n),
    .cs_n      (cs_n),
    .trial     (trial),
    .busy_n    (busy_n),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .pwr_state (pwr_state)
);

// File: tb/sar_conv_ctrl_test.sv
`timescale 1ns/1ps
module sar_conv_ctrl_test;
    localparam int RES_W      = 12;
    localparam int ACQ_CYC    = 15;
    localparam int NAP_WAKE   = 20;
    localparam int SLEEP_WAKE = 200;
    localparam int WORD_W     = RES_W + 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_n = 1'b1;
    logic              cs_n = 1'b0;
    logic              rd_n = 1'b0;
    logic              shdn_n = 1'b1;
    logic              sel_diff = 1'b0;
    logic [2:0]        sel_addr = 3'd0;
    logic              cmp_keep;
    logic [RES_W-1:0]  trial;
    logic              busy_n;
    logic [WORD_W-1:0] dout;
    logic              dout_oe;
    logic [1:0]        pwr_state;
    logic [RES_W-1:0]  vin = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign cmp_keep = (vin >= trial);

    sar_conv_ctrl #(.RES_W(RES_W), .ACQ_CYC(ACQ_CYC), .NAP_WAKE(NAP_WAKE),
                    .SLEEP_WAKE(SLEEP_WAKE)) uut (
        .clk(clk), .rst(rst), .start_n(start_n), .cs_n(cs_n), .rd_n(rd_n),
        .shdn_n(shdn_n), .sel_diff(sel_diff), .sel_addr(sel_addr),
        .cmp_keep(cmp_keep), .trial(trial), .busy_n(busy_n), .dout(dout),
        .dout_oe(dout_oe), .pwr_state(pwr_state)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        start_n = 1'b1;
        repeat (ACQ_CYC + 3) @(negedge clk);
    endtask

    // Runs one conversion; returns at the negedge after the completion edge.
    task automatic run_conv(input logic [RES_W-1:0] v, input logic d, input logic [2:0] a);
        vin = v; sel_diff = d; sel_addr = a;
        @(negedge clk) start_n = 1'b0;
        @(negedge clk);
        chk("R1 busy low after start", busy_n, 0);
        chk("R4 first trial is MSB only", trial, 32'h800);
        repeat (RES_W - 2) @(negedge clk);
        start_n = 1'b1;
        @(negedge clk);
        chk("R4 busy still low at step RES_W", busy_n, 0);
        @(negedge clk);
        chk("R4 busy high after RES_W cycles", busy_n, 1);
        chk("R5 tagged word", dout, {d, a, v});
    endtask

    task automatic t_reset();
        chk("R12 busy_n after reset", busy_n, 1);
        chk("R12 power state active", pwr_state, 0);
        chk("R12 trial zero", trial, 0);
        chk("R12 latch zero", dout, 0);
    endtask

    task automatic t_basic();
        run_conv(12'h5A3, 1'b0, 3'd5);
        settle();
        run_conv(12'hFFF, 1'b1, 3'd7);
        settle();
        run_conv(12'h000, 1'b1, 3'd2);
        settle();
        // second trial follows a dropped MSB
        vin = 12'h3C1; sel_diff = 1'b0; sel_addr = 3'd1;
        @(negedge clk) start_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R4 second trial after dropped MSB", trial, 32'h400);
        start_n = 1'b1;
        repeat (RES_W) @(negedge clk);
        chk("R5 word after bit-order check", dout, {1'b0, 3'd1, 12'h3C1});
        settle();
    endtask

    task automatic t_cs_block();
        cs_n = 1'b1;
        @(negedge clk) start_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R2 start ignored with cs high", busy_n, 1);
        start_n = 1'b1;
        cs_n = 1'b0;
        settle();
    endtask

    task automatic t_restart();
        vin = 12'h7E5; sel_diff = 1'b1; sel_addr = 3'd3;
        @(negedge clk) start_n = 1'b0;
        @(negedge clk);
        repeat (3) @(negedge clk);
        start_n = 1'b1; sel_addr = 3'd6; sel_diff = 1'b0;
        @(negedge clk) start_n = 1'b0;
        repeat (7) @(negedge clk);
        chk("R3 busy low on schedule despite new start", busy_n, 0);
        start_n = 1'b1;
        @(negedge clk);
        chk("R3 ends on schedule", busy_n, 1);
        chk("R3 tag from first start", dout, {1'b1, 3'd3, 12'h7E5});
        settle();
    endtask

    task automatic t_hold();
        logic [WORD_W-1:0] prev;
        run_conv(12'h2B4, 1'b0, 3'd4);
        prev = {1'b0, 3'd4, 12'h2B4};
        vin = 12'h999; sel_addr = 3'd0; sel_diff = 1'b1;
        repeat (ACQ_CYC + 3) @(negedge clk);
        chk("R6 latch holds while idle", dout, prev);
        @(negedge clk) start_n = 1'b0;
        repeat (6) @(negedge clk);
        start_n = 1'b1;
        chk("R6 latch holds during conversion", dout, prev);
        repeat (RES_W - 5) @(negedge clk);
        chk("R6 latch updated on completion", dout, {1'b1, 3'd0, 12'h999});
        settle();
    endtask

    task automatic t_gate();
        @(negedge clk) cs_n = 1'b1; rd_n = 1'b0;
        #1;
        chk("R7 oe low with cs high", dout_oe, 0);
        chk("R7 dout zero with cs high", dout, 0);
        cs_n = 1'b0; rd_n = 1'b1;
        #1;
        chk("R7 oe low with rd high", dout_oe, 0);
        chk("R7 dout zero with rd high", dout, 0);
        rd_n = 1'b0;
        #1;
        chk("R7 oe high with both low", dout_oe, 1);
        chk("R7 dout driven with both low", dout, {1'b1, 3'd0, 12'h999});
    endtask

    task automatic t_power(input bit sleep);
        int w;
        w = sleep ? SLEEP_WAKE : NAP_WAKE;
        @(negedge clk) begin
            cs_n = sleep;
            shdn_n = 1'b0;
        end
        @(negedge clk);
        chk(sleep ? "R8 sleep code" : "R8 nap code", pwr_state, sleep ? 2 : 1);
        if (!sleep) begin
            start_n = 1'b0;
            @(negedge clk);
            @(negedge clk);
            chk("R9 start ignored in nap", busy_n, 1);
            start_n = 1'b1;
            @(negedge clk);
        end
        shdn_n = 1'b1; cs_n = 1'b0;
        @(negedge clk);
        chk("R10 waking after release", pwr_state, 3);
        start_n = 1'b0;
        @(negedge clk);
        chk("R9 start ignored while waking", busy_n, 1);
        start_n = 1'b1;
        repeat (w - 1) @(negedge clk);
        chk("R10 still waking at last count", pwr_state, 3);
        @(negedge clk);
        chk("R10 active after wake count", pwr_state, 0);
        settle();
    endtask

    task automatic t_acq();
        run_conv(12'h111, 1'b0, 3'd1);
        repeat (ACQ_CYC - 1) @(negedge clk);
        start_n = 1'b0;
        @(negedge clk);
        chk("R11 start at window end ignored", busy_n, 1);
        start_n = 1'b1;
        @(negedge clk) start_n = 1'b0;
        @(negedge clk);
        chk("R11 start after window accepted", busy_n, 0);
        start_n = 1'b1;
        repeat (RES_W + 1) @(negedge clk);
        chk("R11 completion of late start", dout, {1'b0, 3'd1, 12'h111});
        settle();
        run_conv(12'h222, 1'b1, 3'd2);
        repeat (ACQ_CYC) @(negedge clk);
        start_n = 1'b0;
        @(negedge clk);
        chk("R11 first allowed edge accepted", busy_n, 0);
        start_n = 1'b1;
        repeat (RES_W + 1) @(negedge clk);
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_cs_block();
        t_restart();
        t_hold();
        t_gate();
        t_power(1'b0);
        t_power(1'b1);
        t_acq();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule